// File: doc/BRIEF.md
# Refresh and RFM Issue-Spacing Checker

This block tells a DRAM command scheduler the earliest cycle at which a row activate, an all-bank refresh or a refresh-management (RFM) command may go to a given logical rank. Ranks form a three-level hierarchy. Several logical ranks share a physical rank, and several physical ranks share a DIMM rank. For each level the block records when the most recent all-bank refresh and the most recent RFM were issued. It also records the most recent activate for each logical rank. RFM keeps its own history, but it is spaced exactly like an all-bank refresh because it holds the rank for the same refresh cycle time.

The scheduler puts a command class and a rank index on the query port. In the same cycle, with no register in the path, the block returns the earliest permitted cycle and a flag that says whether that cycle is the current one. When the scheduler issues a command, it pulses the issue port. The current cycle count is then written as the history stamp at every level that contains the target rank. All spacing values are run-time inputs. The rank index is packed as {DIMM rank, physical rank within DIMM, logical rank within physical rank}, with the logical-rank field in the least significant bits.

Top module: `rfm_spacing_chk`

## Requirements
- R1: After reset, all history is empty and `now_cycle` counts up by one per cycle from 0. Any query then returns `earliest_cycle == now_cycle` and `issue_ok = 1`.
- R2: An activate query (cmd 0) to logical rank L is held until the last all-bank refresh (cmd 1) or RFM (cmd 2) on L, plus `t_rfc_slr - t_cmd_diff`. This amount is clamped at 0.
- R3: Refresh or RFM history on other logical ranks places no bound on an activate query.
- R4: A refresh or RFM query to L is held until a prior refresh or RFM on L plus `t_rfc_slr`.
- R5: A refresh or RFM query is held until a prior refresh or RFM on any logical rank of the same physical rank plus `t_rfc_dlr`.
- R6: A refresh or RFM query is held until a prior refresh or RFM on any rank of the same DIMM rank plus `t_rfc_dpr`.
- R7: A refresh or RFM query to L is held until the last activate on L plus `t_act_ref`.
- R8: `earliest_cycle` is the maximum of `now_cycle` and every bound that applies. `issue_ok` is 1 exactly when that maximum equals `now_cycle`.
- R9: An issue pulse stamps the current `now_cycle` into the history. A query in the same cycle still sees the older history. Queries from the next cycle on see the new stamp.
- R10: A newer issue of the same command class replaces the older stamp at every level it touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A command is issued this cycle |
| issue_cmd | input | 2 | Class of the issued command: 0 activate, 1 all-bank refresh, 2 RFM |
| issue_rank | input | RW | Logical rank index of the issued command |
| query_cmd | input | 2 | Class of the command being asked about |
| query_rank | input | RW | Logical rank index being asked about |
| t_rfc_slr | input | SW | Refresh cycle time within one logical rank |
| t_rfc_dlr | input | SW | Refresh spacing between logical ranks of one physical rank |
| t_rfc_dpr | input | SW | Refresh spacing between physical ranks of one DIMM rank |
| t_cmd_diff | input | SW | Command-length difference taken off the activate-after-refresh spacing |
| t_act_ref | input | SW | Minimum activate-to-refresh spacing on one logical rank |
| now_cycle | output | TW | Current cycle count |
| earliest_cycle | output | TW | Earliest permitted issue cycle for the query |
| issue_ok | output | 1 | The query may issue in the current cycle |

## Verification
After every issue, the bench sweeps every command class against every logical rank of a small 8-rank configuration. This separates same-logical-rank bounds from bounds at the physical and DIMM levels (R4, R5, R6). It also shows that activates ignore refreshes on other ranks (R3). The spacing inputs are set to different values, so it is visible which level's bound won. A value of `t_cmd_diff` that clamps is tried as well.

The issue sequence mixes activates, refreshes and RFMs with varying gaps. Some bounds expire before the query and some do not, which separates the max-with-now rule (R8) from a bare bound. Queries made during the issue cycle show that the new stamp appears one cycle later (R9). Repeated issues to the same rank show that the newer stamp replaces the older one (R10).

// File: rtl/rfm_spacing_pkg.sv
package rfm_spacing_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_REF = 2'd1,
        CMD_RFM = 2'd2
    } cmd_class_e;

    localparam int NUM_LEVELS = 3;   // logical, physical, DIMM
    localparam int NUM_RCLS   = 2;   // refresh-class commands: REF, RFM

    // a stamp plus a spacing, or zero when the stamp was never written
    function automatic logic [31:0] gated_bound(input logic seen,
                                                input logic [31:0] stamp,
                                                input logic [31:0] gap);
        return seen ? (stamp + gap) : 32'd0;
    endfunction

    function automatic logic [31:0] clamp_sub(input logic [31:0] a,
                                              input logic [31:0] b);
        return (a > b) ? (a - b) : 32'd0;
    endfunction

endpackage

// File: rtl/rfm_stamp_table.sv
module rfm_stamp_table #(
    parameter int N  = 2,
    parameter int IW = 1,
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [TW-1:0] wr_time,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_seen,
    output logic [TW-1:0] rd_time
);

    logic [TW-1:0] stamp [N];
    logic [N-1:0]  seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (wr_en) begin
            seen[wr_idx]  <= 1'b1;
            stamp[wr_idx] <= wr_time;
        end
    end

    assign rd_seen = seen[rd_idx];
    assign rd_time = stamp[rd_idx];

    // R1: reset empties every entry
    p_reset_empty_r1: assert property (@(posedge clk) rst |=> (seen == '0));

    // R9, R10: a write is visible from the following cycle and replaces the old stamp
    p_write_visible_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (seen[$past(wr_idx)] && stamp[$past(wr_idx)] == $past(wr_time)));

endmodule

// File: rtl/rfm_spacing_chk.sv
module rfm_spacing_chk
    import rfm_spacing_pkg::*;
#(
    parameter int LOG_BITS = 1,   // logical ranks per physical rank = 2**LOG_BITS
    parameter int PHY_BITS = 1,   // physical ranks per DIMM rank   = 2**PHY_BITS
    parameter int DIM_BITS = 1,   // DIMM ranks                     = 2**DIM_BITS
    parameter int TW       = 20,  // cycle counter width
    parameter int SW       = 10,  // spacing input width
    localparam int RW      = LOG_BITS + PHY_BITS + DIM_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    input  logic [1:0]    issue_cmd,
    input  logic [RW-1:0] issue_rank,
    input  logic [1:0]    query_cmd,
    input  logic [RW-1:0] query_rank,
    input  logic [SW-1:0] t_rfc_slr,
    input  logic [SW-1:0] t_rfc_dlr,
    input  logic [SW-1:0] t_rfc_dpr,
    input  logic [SW-1:0] t_cmd_diff,
    input  logic [SW-1:0] t_act_ref,
    output logic [TW-1:0] now_cycle,
    output logic [TW-1:0] earliest_cycle,
    output logic          issue_ok
);

    localparam int NRANK = 1 << RW;

    cmd_class_e q_cmd, i_cmd;
    assign q_cmd = cmd_class_e'(query_cmd);
    assign i_cmd = cmd_class_e'(issue_cmd);

    // free-running cycle counter
    always_ff @(posedge clk) begin
        if (rst) now_cycle <= '0;
        else     now_cycle <= now_cycle + 1'b1;
    end

    // refresh-class history at every hierarchy level
    logic          rc_seen [NUM_LEVELS][NUM_RCLS];
    logic [TW-1:0] rc_time [NUM_LEVELS][NUM_RCLS];

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
        localparam int SH   = (lv == 0) ? 0 : (lv == 1) ? LOG_BITS : LOG_BITS + PHY_BITS;
        localparam int BITS = RW - SH;
        for (genvar c = 0; c < NUM_RCLS; c++) begin : g_cls
            localparam cmd_class_e MATCH = (c == 0) ? CMD_REF : CMD_RFM;
            rfm_stamp_table #(.N(1 << BITS), .IW(BITS), .TW(TW)) u_tab (
                .clk    (clk),
                .rst    (rst),
                .wr_en  (issue_valid && i_cmd == MATCH),
                .wr_idx (issue_rank[RW-1:SH]),
                .wr_time(now_cycle),
                .rd_idx (query_rank[RW-1:SH]),
                .rd_seen(rc_seen[lv][c]),
                .rd_time(rc_time[lv][c])
            );
        end
    end

    // activate history per logical rank
    logic          act_seen;
    logic [TW-1:0] act_time;

    rfm_stamp_table #(.N(NRANK), .IW(RW), .TW(TW)) u_act_tab (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (issue_valid && i_cmd == CMD_ACT),
        .wr_idx (issue_rank),
        .wr_time(now_cycle),
        .rd_idx (query_rank),
        .rd_seen(act_seen),
        .rd_time(act_time)
    );

    // per-level spacing
    logic [31:0] lvl_gap [NUM_LEVELS];
    assign lvl_gap[0] = 32'(t_rfc_slr);
    assign lvl_gap[1] = 32'(t_rfc_dlr);
    assign lvl_gap[2] = 32'(t_rfc_dpr);

    logic [31:0] act_gap;
    assign act_gap = clamp_sub(32'(t_rfc_slr), 32'(t_cmd_diff));

    // maximum over the applicable bounds and the current cycle
    always_comb begin
        logic [31:0] best;
        logic [31:0] cand;
        best = 32'(now_cycle);
        if (q_cmd == CMD_ACT) begin
            for (int c = 0; c < NUM_RCLS; c++) begin
                cand = gated_bound(rc_seen[0][c], 32'(rc_time[0][c]), act_gap);
                if (cand > best) best = cand;
            end
        end else begin
            for (int lv = 0; lv < NUM_LEVELS; lv++) begin
                for (int c = 0; c < NUM_RCLS; c++) begin
                    cand = gated_bound(rc_seen[lv][c], 32'(rc_time[lv][c]), lvl_gap[lv]);
                    if (cand > best) best = cand;
                end
            end
            cand = gated_bound(act_seen, 32'(act_time), 32'(t_act_ref));
            if (cand > best) best = cand;
        end
        earliest_cycle = best[TW-1:0];
    end

    assign issue_ok = (earliest_cycle == now_cycle);

    // R1: counter restarts at zero and steps by one
    p_now_zero_r1: assert property (@(posedge clk) rst |=> (now_cycle == '0));
    p_now_step_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (now_cycle == $past(now_cycle) + 1'b1));
    // R1: right after reset nothing holds a query back
    p_idle_ready_r1: assert property (@(posedge clk) rst |=> issue_ok);
    // R4: a refresh-class query to the same logical rank one cycle after a refresh-class issue waits
    p_ref_back_to_back_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(issue_valid) && $past(issue_cmd) != 2'd0 && query_cmd != 2'd0 &&
         query_rank == $past(issue_rank) && t_rfc_slr > 1) |-> !issue_ok);

endmodule

// File: tb/rfm_spacing_chk_bench.sv
module rfm_spacing_chk_bench;

    localparam int LB = 1, PB = 1, DB = 1;
    localparam int RW = LB + PB + DB;
    localparam int NR = 1 << RW;
    localparam int TW = 16, SW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_valid = 1'b0;
    logic [1:0]    issue_cmd = 2'd0;
    logic [RW-1:0] issue_rank = '0;
    logic [1:0]    query_cmd = 2'd0;
    logic [RW-1:0] query_rank = '0;
    logic [SW-1:0] t_rfc_slr = 10'd20, t_rfc_dlr = 10'd8, t_rfc_dpr = 10'd4;
    logic [SW-1:0] t_cmd_diff = 10'd3, t_act_ref = 10'd6;
    logic [TW-1:0] now_cycle, earliest_cycle;
    logic          issue_ok;

    rfm_spacing_chk #(.LOG_BITS(LB), .PHY_BITS(PB), .DIM_BITS(DB), .TW(TW), .SW(SW)) u_rfm_spacing_chk (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_cmd(issue_cmd),
        .issue_rank(issue_rank), .query_cmd(query_cmd), .query_rank(query_rank),
        .t_rfc_slr(t_rfc_slr), .t_rfc_dlr(t_rfc_dlr), .t_rfc_dpr(t_rfc_dpr),
        .t_cmd_diff(t_cmd_diff), .t_act_ref(t_act_ref),
        .now_cycle(now_cycle), .earliest_cycle(earliest_cycle), .issue_ok(issue_ok));

    always #10 clk = ~clk;   // 50 MHz

    int tb_now = 0;
    always @(posedge clk) tb_now <= rst ? 0 : tb_now + 1;

    int n_vec = 0, n_bad = 0;
    int lref [NR], lrfm [NR], lact [NR];
    string tag;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // expected earliest cycle, from the requirements
    function automatic int model(int cmd, int r);
        int e, b, sp, t, ag;
        e = tb_now; tag = "R8";
        if (cmd == 0) begin
            ag = max2(int'(t_rfc_slr) - int'(t_cmd_diff), 0);
            for (int k = 0; k < 2; k++) begin
                t = (k == 0) ? lref[r] : lrfm[r];
                if (t >= 0 && t + ag > e) begin e = t + ag; tag = "R2"; end
            end
            if (tag == "R8") tag = "R3";   // other ranks' refreshes must not count
        end else begin
            for (int q = 0; q < NR; q++) begin
                for (int k = 0; k < 2; k++) begin
                    t = (k == 0) ? lref[q] : lrfm[q];
                    if (t < 0) continue;
                    if (q == r)
                        sp = max2(int'(t_rfc_slr), max2(int'(t_rfc_dlr), int'(t_rfc_dpr)));
                    else if ((q >> LB) == (r >> LB))
                        sp = max2(int'(t_rfc_dlr), int'(t_rfc_dpr));
                    else if ((q >> (LB + PB)) == (r >> (LB + PB)))
                        sp = int'(t_rfc_dpr);
                    else continue;
                    b = t + sp;
                    if (b > e) begin
                        e = b;
                        tag = (q == r) ? "R4" : ((q >> LB) == (r >> LB)) ? "R5" : "R6";
                    end
                end
            end
            if (lact[r] >= 0 && lact[r] + int'(t_act_ref) > e) begin
                e = lact[r] + int'(t_act_ref); tag = "R7";
            end
        end
        return e;
    endfunction

    // called at a point away from the clock edge with the query already driven
    task automatic compare(int cmd, int r, string force_tag);
        int e;
        e = model(cmd, r);
        if (force_tag != "") tag = force_tag;
        n_vec++;
        if (int'(earliest_cycle) != e || issue_ok != (e == tb_now) || int'(now_cycle) != tb_now) begin
            n_bad++;
            $display("FAIL %s cmd=%0d rank=%0d: earliest=%0d ok=%0d now=%0d, expected earliest=%0d ok=%0d now=%0d",
                     tag, cmd, r, earliest_cycle, issue_ok, now_cycle, e, (e == tb_now), tb_now);
        end
    endtask

    task automatic probe(int cmd, int r, string force_tag);
        @(negedge clk);
        query_cmd = 2'(cmd); query_rank = RW'(r);
        #2 compare(cmd, r, force_tag);
    endtask

    task automatic sweep(string force_tag);
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < 3; c++) probe(c, r, force_tag);
    endtask

    task automatic issue(int cmd, int r);
        @(negedge clk);
        issue_valid = 1'b1; issue_cmd = 2'(cmd); issue_rank = RW'(r);
        query_cmd = 2'(cmd); query_rank = RW'(r);
        #2 compare(cmd, r, "R9");   // same-cycle query still sees old history
        if (cmd == 0) lact[r] = tb_now;
        else if (cmd == 1) lref[r] = tb_now;
        else lrfm[r] = tb_now;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #3000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin lref[i] = -1; lrfm[i] = -1; lact[i] = -1; end
        idle(3);
        @(negedge clk) rst = 1'b0;
        // R1: empty history right after reset
        sweep("R1");
        // RFM on rank 0: R2 on rank 0, R3 elsewhere, R4/R5/R6 levels
        issue(2, 0);
        sweep("");
        idle(5);
        sweep("");
        // R7: activate then refresh query on the same rank
        issue(0, 6);
        sweep("");
        issue(1, 5);
        sweep("");
        // R10: a newer refresh on the same rank replaces the old stamp
        idle(25);
        issue(1, 5);
        probe(1, 5, "R10");
        probe(1, 4, "R10");
        // clamped activate spacing (R2)
        t_cmd_diff = 10'd30;
        issue(1, 3);
        probe(0, 3, "R2");
        t_cmd_diff = 10'd3;
        // mixed sequence with varying gaps
        for (int i = 0; i < 40; i++) begin
            issue(i % 3, (i * 5 + i / 8) % NR);
            idle(i % 7);
            sweep("");
        end
        // R1: reset clears everything again
        @(negedge clk) rst = 1'b1;
        idle(2);
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < NR; i++) begin lref[i] = -1; lrfm[i] = -1; lact[i] = -1; end
        sweep("R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule